// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

This block turns a bank of wired interrupt lines into message-signalled interrupt writes for a downstream translation service. Each line passes through a two-flop synchronizer. Its trigger mode then decides when a pending status bit is set. Rising-edge mode sets pending on a 0-to-1 transition. Level-high mode sets pending while the line is high and pending is clear.

Every pending line produces exactly one message on a valid/ready output. The message carries a fixed doorbell address, which is a design parameter. It also carries the device and event identifiers held in that line's vector register. Software reaches the block over a simple single-cycle register bus. Trigger-mode words and vector registers sit in the node window at `NODE_ID * 0x1000`. A write-one-to-clear status array sits at 0xA000 and is indexed by global interrupt number.

The global numbering works as follows. The first 64 numbers are reserved. Node pin `p` has number `64 + 128*(NODE_ID-1) + p`. Pending lines are served in round-robin order.

Top module: `wim_top`

## Requirements
- R1: After reset, `msg_valid` is 0, all pending bits are 0, and every trigger-mode word and vector register reads as 0.
- R2: Trigger-mode word `w` is at node offset `4*w`. Bit `b` of that word selects the mode of pin `32*w+b`: 1 means level-high, 0 means rising-edge. The word reads back as written.
- R3: The vector register of pin `p` is at node offset `0x200 + 4*p`. Bits [11:0] hold the device identifier and bits [21:12] hold the event identifier. A read returns bits [21:0] as written, with bits [31:22] as 0.
- R4: A rising-edge pin raises exactly one message per 0-to-1 transition. A line that stays high sends nothing further, even after its pending bit is cleared.
- R5: A level-high pin raises one message when its line is high. Clearing its pending bit while the line is still high raises exactly one more message.
- R6: Status word `k` is at 0xA000 + 4*k and covers interrupt numbers 32k..32k+31, one bit each. Reading the word returns the pending bits. Writing 1 to a bit clears that interrupt's pending status. Pending never drops without such a write.
- R7: A message carries `msg_addr` equal to the DOORBELL parameter, plus the device and event identifiers of the served pin. All message fields stay stable while `msg_valid` is high and `msg_ready` is low.
- R8: When several pins are pending at once, they are served in increasing pin order, cyclically, starting after the most recently served pin.
- R9: Clear-array bits whose numbers map to no pin of this node have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_PINS | Wired interrupt lines, asynchronous |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | DB_W | Fixed doorbell address |
| msg_dev | output | 12 | Device identifier |
| msg_evt | output | 10 | Event identifier |

## Verification
Assertions check three things on every cycle. An offered message is held unchanged until it is accepted. A served pin was actually requesting service. A pending bit never falls without a clear write, and the sent-mark is never set for a pin that is not pending.

Other behaviours only show up in the bench's scenarios. These are the difference between edge and level re-firing after a clear, the round-robin order across simultaneous requests, the address decoding of vector, mode and status words, and the fact that reserved status bits are ignored.

// File: rtl/wim_pkg.sv
// Shared types for the wired interrupt to message converter.
// Assumes a 12-bit device identifier and a 10-bit event identifier.
package wim_pkg;
    localparam int DEV_W = 12;
    localparam int EVT_W = 10;

    // Vector register contents; the event sits above the device field.
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [DEV_W-1:0] dev;
    } wim_vec_t;
endpackage

// File: rtl/wim_sync.sv
// Two-flop synchronizer for the interrupt lines plus a previous-value flop.
// Produces the synchronized level and a single-cycle rising-edge pulse.
// Assumes lines are held at least two clocks per level.
module wim_sync #(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic [NUM_PINS-1:0] lvl,
    output logic [NUM_PINS-1:0] rise
);
    logic [NUM_PINS-1:0] s1_q, s2_q, s3_q;

    // Synchronize the lines and remember the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= irq_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/wim_regfile.sv
// Register file and per-pin pending/sent state.
// Decodes mode words and vector registers in the node window, and the
// write-one-to-clear status array at 0xA000. Assumes NUM_PINS is a multiple
// of 32 and NODE_ID is between 1 and 9.
module wim_regfile
    import wim_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int NODE_ID  = 1,
    localparam int PIN_W      = $clog2(NUM_PINS),
    localparam int TYPE_WORDS = NUM_PINS / 32,
    localparam int FIRST_NUM  = 64 + 128 * (NODE_ID - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [15:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] rise,
    input  logic                acc_en,
    input  logic [PIN_W-1:0]    acc_pin,
    input  logic [PIN_W-1:0]    lookup_pin,
    output wim_vec_t            lookup_vec,
    output logic [NUM_PINS-1:0] req
);
    logic [NUM_PINS-1:0] type_q, pend_q, sent_q, clr, set, acc_vec;
    wim_vec_t            vec_q [NUM_PINS];
    logic                node_hit, type_hit, vec_hit, clr_hit, we;
    logic [9:0]          word, vidx;

    // Address decode for the three register regions.
    always_comb begin
        word     = bus_addr[11:2];
        vidx     = word - 10'h080;
        node_hit = bus_en && (bus_addr[1:0] == 2'b00) && (bus_addr[15:12] == 4'(NODE_ID));
        type_hit = node_hit && (32'(word) < TYPE_WORDS);
        vec_hit  = node_hit && (word >= 10'h080) && (32'(vidx) < NUM_PINS);
        clr_hit  = bus_en && (bus_addr[1:0] == 2'b00) && (bus_addr[15:12] == 4'hA);
        we       = bus_wr;
    end

    // Per-pin clear strobes, set conditions and accept mark.
    always_comb begin
        clr     = '0;
        acc_vec = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            clr[p] = clr_hit && we && (word == 10'((FIRST_NUM + p) / 32))
                     && bus_wdata[(FIRST_NUM + p) % 32];
            set[p] = type_q[p] ? (lvl[p] & ~pend_q[p]) : rise[p];
        end
        if (acc_en) acc_vec[acc_pin] = 1'b1;
    end

    // Software-visible mode words and vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) vec_q[p] <= '0;
        end else if (we) begin
            for (int w = 0; w < TYPE_WORDS; w++)
                if (type_hit && 32'(word) == w) type_q[w*32 +: 32] <= bus_wdata;
            if (vec_hit) vec_q[vidx[PIN_W-1:0]] <= bus_wdata[21:0];
        end
    end

    // Pending status and the mark that its message has been delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            sent_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | set;
            sent_q <= (sent_q & ~clr) | (acc_vec & pend_q & ~clr);
        end
    end

    // Read data multiplexer; unmapped addresses read as zero.
    always_comb begin
        bus_rdata = '0;
        if (type_hit) begin
            for (int w = 0; w < TYPE_WORDS; w++)
                if (32'(word) == w) bus_rdata = type_q[w*32 +: 32];
        end else if (vec_hit) begin
            bus_rdata = {10'b0, vec_q[vidx[PIN_W-1:0]]};
        end else if (clr_hit) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (word == 10'((FIRST_NUM + p) / 32))
                    bus_rdata[(FIRST_NUM + p) % 32] = pend_q[p];
        end
    end

    assign req        = pend_q & ~sent_q;
    assign lookup_vec = vec_q[lookup_pin];

    // A delivered mark only exists for a pin that is still pending.
    assert_sent_in_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_q & ~pend_q) == '0);

    // A pending bit only falls in the cycle after a clear write to it.
    assert_pend_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q) & ~$past(clr)) == '0);
endmodule

// File: rtl/wim_rr_arb.sv
// Round-robin selection of requesting pins and the output message register.
// Searches cyclically from the pin after the last one served. Leaves one idle
// cycle between messages so the served pin's request has dropped.
module wim_rr_arb
    import wim_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] req,
    input  wim_vec_t            lookup_vec,
    output logic [PIN_W-1:0]    lookup_pin,
    input  logic                msg_ready,
    output logic                msg_valid,
    output logic [DEV_W-1:0]    msg_dev,
    output logic [EVT_W-1:0]    msg_evt,
    output logic                acc_en,
    output logic [PIN_W-1:0]    acc_pin
);
    logic [PIN_W-1:0] ptr_q, pin_q, sel;
    logic             found, launch, valid_q;
    wim_vec_t         msg_q;

    // Cyclic priority search starting after the last served pin.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            logic [PIN_W-1:0] idx;
            idx = PIN_W'((int'(ptr_q) + 1 + i) % NUM_PINS);
            if (!found && req[idx]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
        launch = !valid_q && found;
    end

    // Load a message on launch and drop it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ptr_q   <= PIN_W'(NUM_PINS - 1);
            pin_q   <= '0;
            msg_q   <= '0;
        end else if (launch) begin
            valid_q <= 1'b1;
            ptr_q   <= sel;
            pin_q   <= sel;
            msg_q   <= lookup_vec;
        end else if (valid_q && msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign lookup_pin = sel;
    assign msg_valid  = valid_q;
    assign msg_dev    = msg_q.dev;
    assign msg_evt    = msg_q.evt;
    assign acc_en     = valid_q && msg_ready;
    assign acc_pin    = pin_q;

    // An offered message stays unchanged until it is taken.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !msg_ready) |=> (valid_q && $stable(msg_q) && $stable(pin_q)));

    // Only a requesting pin is ever served.
    assert_grant_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> $past(req[sel]));
endmodule

// File: rtl/wim_top.sv
// Wired interrupt to message converter top level.
// Synchronizes lines, keeps pending state and registers, and emits one
// message per pending event to a fixed doorbell address.
module wim_top
    import wim_pkg::*;
#(
    parameter int          NUM_PINS = 64,
    parameter int          NODE_ID  = 1,
    parameter int          DB_W     = 32,
    parameter logic [31:0] DOORBELL = 32'h0800_0040,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [15:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [DB_W-1:0]     msg_addr,
    output logic [DEV_W-1:0]    msg_dev,
    output logic [EVT_W-1:0]    msg_evt
);
    logic [NUM_PINS-1:0] lvl, rise, req;
    logic                acc_en;
    logic [PIN_W-1:0]    acc_pin, lookup_pin;
    wim_vec_t            lookup_vec;

    wim_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl(lvl), .rise(rise)
    );

    wim_regfile #(.NUM_PINS(NUM_PINS), .NODE_ID(NODE_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvl(lvl), .rise(rise), .acc_en(acc_en), .acc_pin(acc_pin),
        .lookup_pin(lookup_pin), .lookup_vec(lookup_vec), .req(req)
    );

    wim_rr_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .lookup_vec(lookup_vec),
        .lookup_pin(lookup_pin), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_dev(msg_dev), .msg_evt(msg_evt), .acc_en(acc_en), .acc_pin(acc_pin)
    );

    assign msg_addr = DB_W'(DOORBELL);
endmodule

// File: tb/wim_top_tb.sv
// Self-checking bench: seeded random vectors and pins plus directed cases.
module wim_top_tb;
    localparam int N = 64;
    localparam logic [31:0] DB = 32'h0800_0040;

    logic        clk = 0, rst_n = 0;
    logic [N-1:0] irq_in = '0;
    logic        bus_en = 0, bus_wr = 0, msg_ready = 0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        msg_valid;
    logic [31:0] msg_addr;
    logic [11:0] msg_dev;
    logic [9:0]  msg_evt;
    int checks = 0, fails = 0, last = N - 1;
    logic [21:0] vec_model [N];

    always #2 clk = ~clk;

    wim_top u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_dev(msg_dev), .msg_evt(msg_evt));

    function automatic logic [15:0] vec_addr(int p); return 16'(32'h1200 + 4 * p); endfunction
    function automatic logic [15:0] st_addr(int p); return 16'(32'hA000 + 4 * ((64 + p) / 32)); endfunction
    function automatic logic [31:0] st_bit(int p); return 32'h1 << ((64 + p) % 32); endfunction
    function automatic int rr_next(int from, logic [N-1:0] m);
        for (int i = 1; i <= N; i++) if (m[(from + i) % N]) return (from + i) % N;
        return -1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata; bus_en = 0;
    endtask

    task automatic set_vec(int p, logic [21:0] v);
        vec_model[p] = v; wr(vec_addr(p), {10'h3FF, v});
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int i = 0; i < 12 && !got; i++) begin @(negedge clk); got = msg_valid; end
    endtask

    task automatic accept;
        @(negedge clk); msg_ready = 1; @(negedge clk); msg_ready = 0;
    endtask

    // Expect one message for pin p with the modelled vector, then take it.
    task automatic expect_msg(string req, int p);
        bit got;
        wait_msg(got);
        chk(req, 32'(got), 1);
        chk(req, msg_addr, DB);
        chk(req, {10'b0, msg_evt, msg_dev}, {10'b0, vec_model[p]});
        accept();
        last = p;
    endtask

    task automatic expect_quiet(string req);
        bit got;
        wait_msg(got);
        chk(req, 32'(got), 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d, w;
        logic [11:0] dv [4];
        logic [9:0]  ev [4];
        int p, q, pins [3];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) vec_model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 valid", 32'(msg_valid), 0);
        rd(16'h1000, d); chk("R1 mode", d, 0);
        rd(vec_addr(17), d); chk("R1 vector", d, 0);
        rd(16'hA008, d); chk("R1 pending", d, 0);

        // R2: mode words read back
        for (int k = 0; k < 2; k++) begin
            w = $urandom; wr(16'(16'h1000 + 4 * k), w);
            rd(16'(16'h1000 + 4 * k), d); chk("R2 mode readback", d, w);
        end
        wr(16'h1000, 0); wr(16'h1004, 0);

        // R3: vector registers, random contents, upper bits read as zero
        for (int k = 0; k < 6; k++) begin
            p = $urandom % N; w = $urandom;
            wr(vec_addr(p), w); vec_model[p] = w[21:0];
            rd(vec_addr(p), d); chk("R3 vector readback", d, {10'b0, w[21:0]});
        end
        for (int i = 0; i < N; i++) set_vec(i, {10'((i * 7 + 3) % 1024), 12'((i * 13 + 256) % 4096)});

        // R4 and R7: rising-edge pin, held message, no repeat while high
        p = 37;
        irq_in[p] = 1;
        begin
            bit got;
            wait_msg(got); chk("R4 fired", 32'(got), 1);
            repeat (3) begin
                @(negedge clk);
                chk("R7 held valid", 32'(msg_valid), 1);
                chk("R7 held fields", {msg_evt, msg_dev}, {10'b0, vec_model[p]});
            end
            chk("R7 doorbell", msg_addr, DB);
            accept(); last = p;
        end
        expect_quiet("R4 no repeat");
        rd(st_addr(p), d); chk("R6 pending visible", d, st_bit(p));
        wr(st_addr(p), st_bit(p));
        rd(st_addr(p), d); chk("R6 cleared", d, 0);
        expect_quiet("R4 no refire after clear");
        irq_in[p] = 0;

        // R5: level pin re-fires after clear while still high
        q = 5;
        wr(16'h1000, 32'h1 << q);
        irq_in[q] = 1;
        expect_msg("R5 first", q);
        expect_quiet("R5 single");
        wr(st_addr(q), st_bit(q));
        expect_msg("R5 refire", q);
        irq_in[q] = 0;
        repeat (4) @(negedge clk);
        wr(st_addr(q), st_bit(q));
        expect_quiet("R5 quiet after drop");
        rd(st_addr(q), d); chk("R5 pending clear", d, 0);
        wr(16'h1000, 0);

        // R8: simultaneous requests served cyclically after the last served
        repeat (2) begin
            logic [N-1:0] m;
            int cur;
            m = '0;
            pins[0] = $urandom % N;
            pins[1] = (pins[0] + 11 + $urandom % 20) % N;
            pins[2] = (pins[1] + 11 + $urandom % 20) % N;
            for (int k = 0; k < 3; k++) begin m[pins[k]] = 1; irq_in[pins[k]] = 1; end
            cur = last;
            for (int k = 0; k < 3; k++) begin
                cur = rr_next(cur, m);
                m[cur] = 0;
                expect_msg("R8 order", cur);
            end
            irq_in = '0;
            wr(16'hA008, 32'hFFFF_FFFF); wr(16'hA00C, 32'hFFFF_FFFF);
        end

        // R9: reserved and foreign clear bits ignored; unmapped reads zero
        p = 40;
        irq_in[p] = 1;
        expect_msg("R9 setup", p);
        wr(16'hA000, 32'hFFFF_FFFF); wr(16'hA004, 32'hFFFF_FFFF); wr(16'hA010, 32'hFFFF_FFFF);
        rd(st_addr(p), d); chk("R9 pending kept", d, st_bit(p));
        rd(16'hA010, d); chk("R9 foreign word", d, 0);
        rd(16'h1100, d); chk("R9 unmapped node", d, 0);
        rd(16'h0000, d); chk("R9 reserved node", d, 0);
        wr(st_addr(p), st_bit(p)); irq_in[p] = 0;

        // R4 and R7: random pins with fresh random vectors
        for (int k = 0; k < 20; k++) begin
            p = $urandom % N;
            set_vec(p, 22'($urandom));
            repeat (3) @(negedge clk);
            irq_in[p] = 1;
            expect_msg("R7 random content", p);
            irq_in[p] = 0;
            wr(st_addr(p), st_bit(p));
            rd(st_addr(p), d); chk("R6 random clear", d & st_bit(p), 0);
        end
        expect_quiet("R4 idle at end");
        summary();
    end
endmodule